// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer

This block takes read requests from a host and turns them into row-select and column-select strobes for a page-mode DRAM array. It counts the wait cycles for every data beat. It remembers which row (page) was opened last. A request whose row matches that page goes straight to column select. A request to any other row opens the new row first and pays the row setup cost as well.

A burst request returns four words. They are the addressed word and the other three words of its aligned group of four, in ascending order, wrapping at the group boundary. Burst mode can be enabled at run time. When it is enabled, each follow-on beat costs only a programmable beat time, which gives profiles such as 5-3-3-3 or 5-2-2-2. When it is disabled, every beat re-selects the row and pays row plus column time, which gives 5-5-5-5.

The cycle counts come from configuration inputs. These inputs must be at least 1 and must stay stable while the block is busy. The memory model returns read data combinationally from the selected row and column.

Top module: `page_burst_seq`

## Requirements
- R1: After reset, busy, rvalid, rowStrobe and colStrobe are low and no page is open, so the first request is always a page miss.
- R2: A request (req high) is accepted in a cycle where busy is low. busy is high from the next cycle up to and including the cycle of the last rvalid, and low in the cycle after it.
- R3: On a page miss accepted in cycle k, rowStrobe is high in cycle k+1 and the first rvalid is in cycle k+cfgRowCycles+cfgColCycles.
- R4: On a page hit accepted in cycle k, rowStrobe stays low for the first beat, colStrobe is high in cycle k+1, and the first rvalid is in cycle k+cfgColCycles.
- R5: A burst request (burst high) gives four rvalid beats. Their word addresses keep address bits [15:2] and count bits [1:0] upward from the request, wrapping from 3 to 0.
- R6: With cfgBurstMode high, each follow-on beat arrives cfgBeatCycles after the previous one with no rowStrobe. Settings 2/3/3 give 5-3-3-3 (last word in cycle k+14), and 2/3/2 give 5-2-2-2 (k+11).
- R7: With cfgBurstMode low, every follow-on beat pulses rowStrobe and arrives cfgRowCycles+cfgColCycles after the previous one (5-5-5-5 for 2/3).
- R8: A request with burst low gives exactly one rvalid beat.
- R9: During rvalid, rdata equals memRdata for the row and column last strobed. The row is address bits [15:8] and the column is bits [7:0] with the default 1024-byte page of 4-byte words.
- R10: Each page miss makes the requested row the open page, so a later request to that row is a hit.
- R11: A request raised while busy is high is ignored. It neither changes the beats in progress nor the open page.
- R12: Within a burst, each follow-on column strobe keeps column bits above the group and advances the low two bits by one, modulo four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request |
| addr | input | ADDR_W | Word address of request |
| burst | input | 1 | Request four words instead of one |
| cfgRowCycles | input | CNT_W | Row setup cycles (at least 1) |
| cfgColCycles | input | CNT_W | Column cycles of a first or unbursted beat (at least 1) |
| cfgBeatCycles | input | CNT_W | Cycles of a follow-on burst beat (at least 1) |
| cfgBurstMode | input | 1 | Follow-on beats skip row setup when high |
| busy | output | 1 | Sequencer occupied; requests ignored |
| rvalid | output | 1 | Read data valid this cycle |
| rdata | output | DATA_W | Read data |
| rowStrobe | output | 1 | Row select pulse, memRow valid |
| colStrobe | output | 1 | Column select pulse, memCol valid |
| memRow | output | ROW_W | Row address to the array |
| memCol | output | COL_W | Column address to the array |
| memRdata | input | DATA_W | Data returned by the array |

## Verification
The hardest states to reach from the ports are a page hit that follows a rejected request and a burst whose start lies mid-group. The rejected request must have left the open page untouched, and the start position must wrap at the group boundary. The stimulus raises a request for a different row in the middle of a burst. It then issues a single read to the original page and expects hit timing. Bursts start at offsets 1 and 3 of a group so that the column wrap shows in the returned data. The bench's memory model latches row and column only on their strobes and encodes both into each data word. A missing or misplaced strobe therefore shows up as wrong data.

// File: rtl/page_burst_seq_pkg.sv
package page_burst_seq_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W = $clog2(BURST_LEN);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ROW, SEQ_COL} seqState_t;

  typedef struct packed {
    logic accept;   // capture request address, update page
    logic colStep;  // advance column within the burst group
  } seqCtrl_t;
endpackage

// File: rtl/page_burst_seq_ctrl.sv
module page_burst_seq_ctrl
  import page_burst_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic             burst,
  input  logic             pageHit,
  input  logic [CNT_W-1:0] cfgRowCycles,
  input  logic [CNT_W-1:0] cfgColCycles,
  input  logic [CNT_W-1:0] cfgBeatCycles,
  input  logic             cfgBurstMode,
  output seqCtrl_t         ctrl,
  output logic             busy,
  output logic             rvalid,
  output logic             rowStrobe,
  output logic             colStrobe
);
  seqState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext, followCost;
  logic [BEAT_W-1:0] beatIdx, beatNext;
  logic burstReg, rowPulse, colPulse, enterRow, enterCol, lastBeat;

  assign busy      = (state != SEQ_IDLE);
  assign rvalid    = (state == SEQ_COL) && (cnt == '0);
  assign rowStrobe = rowPulse;
  assign colStrobe = colPulse;
  assign lastBeat  = !burstReg || (beatIdx == BEAT_W'(BURST_LEN - 1));
  assign followCost = (cfgBurstMode && beatIdx != '0) ? cfgBeatCycles : cfgColCycles;

  always_comb begin
    stateNext    = state;
    cntNext      = cnt;
    beatNext     = beatIdx;
    enterRow     = 1'b0;
    enterCol     = 1'b0;
    ctrl.accept  = 1'b0;
    ctrl.colStep = 1'b0;
    case (state)
      SEQ_IDLE: if (req) begin
        ctrl.accept = 1'b1;
        beatNext    = '0;
        if (pageHit) begin
          stateNext = SEQ_COL;
          cntNext   = cfgColCycles - 1'b1;
          enterCol  = 1'b1;
        end else begin
          stateNext = SEQ_ROW;
          cntNext   = cfgRowCycles - 1'b1;
          enterRow  = 1'b1;
        end
      end
      SEQ_ROW: if (cnt == '0) begin
        stateNext = SEQ_COL;
        cntNext   = followCost - 1'b1;
        enterCol  = 1'b1;
      end else begin
        cntNext = cnt - 1'b1;
      end
      SEQ_COL: if (cnt != '0) begin
        cntNext = cnt - 1'b1;
      end else if (lastBeat) begin
        stateNext = SEQ_IDLE;
      end else begin
        ctrl.colStep = 1'b1;
        beatNext     = beatIdx + 1'b1;
        if (cfgBurstMode) begin
          cntNext  = cfgBeatCycles - 1'b1;
          enterCol = 1'b1;
        end else begin
          stateNext = SEQ_ROW;
          cntNext   = cfgRowCycles - 1'b1;
          enterRow  = 1'b1;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      cnt      <= '0;
      beatIdx  <= '0;
      burstReg <= 1'b0;
      rowPulse <= 1'b0;
      colPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      beatIdx  <= beatNext;
      rowPulse <= enterRow;
      colPulse <= enterCol;
      if (ctrl.accept) burstReg <= burst;
    end
  end
endmodule

// File: rtl/page_burst_seq_dp.sv
module page_burst_seq_dp
  import page_burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int COL_W  = 8,
  parameter int ROW_W  = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  seqCtrl_t          ctrl,
  input  logic [DATA_W-1:0] memRdata,
  output logic              pageHit,
  output logic [ROW_W-1:0]  memRow,
  output logic [COL_W-1:0]  memCol,
  output logic [DATA_W-1:0] rdata
);
  logic pageOpen;
  logic [ROW_W-1:0] reqRow;

  assign reqRow  = addr[ADDR_W-1:COL_W];
  assign pageHit = pageOpen && (reqRow == memRow);
  assign rdata   = memRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageOpen <= 1'b0;
      memRow   <= '0;
      memCol   <= '0;
    end else if (ctrl.accept) begin
      pageOpen <= 1'b1;
      memRow   <= reqRow;
      memCol   <= addr[COL_W-1:0];
    end else if (ctrl.colStep) begin
      memCol <= {memCol[COL_W-1:BEAT_W], memCol[BEAT_W-1:0] + 1'b1};
    end
  end
endmodule

// File: rtl/page_burst_seq.sv
module page_burst_seq
  import page_burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int PAGE_BYTES = 1024,
  parameter int CNT_W      = 4,
  localparam int PAGE_WORDS = PAGE_BYTES / WORD_BYTES,
  localparam int COL_W      = $clog2(PAGE_WORDS),
  localparam int ROW_W      = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst,
  input  logic [CNT_W-1:0]  cfgRowCycles,
  input  logic [CNT_W-1:0]  cfgColCycles,
  input  logic [CNT_W-1:0]  cfgBeatCycles,
  input  logic              cfgBurstMode,
  output logic              busy,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              rowStrobe,
  output logic              colStrobe,
  output logic [ROW_W-1:0]  memRow,
  output logic [COL_W-1:0]  memCol,
  input  logic [DATA_W-1:0] memRdata
);
  seqCtrl_t ctrl;
  logic pageHit;

  page_burst_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .burst(burst), .pageHit(pageHit),
    .cfgRowCycles(cfgRowCycles), .cfgColCycles(cfgColCycles),
    .cfgBeatCycles(cfgBeatCycles), .cfgBurstMode(cfgBurstMode),
    .ctrl(ctrl), .busy(busy), .rvalid(rvalid),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe)
  );

  page_burst_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .ctrl(ctrl), .memRdata(memRdata),
    .pageHit(pageHit), .memRow(memRow), .memCol(memCol), .rdata(rdata)
  );
endmodule

// File: rtl/page_burst_seq_chk.sv
module page_burst_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             req,
  input logic             busy,
  input logic             rvalid,
  input logic             rowStrobe,
  input logic             colStrobe,
  input logic             pageHit,
  input logic [COL_W-1:0] memCol
);
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (req && !busy) |=> busy); // R2
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |-> busy); // R2
  AST_HIT_SKIPS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (req && !busy && pageHit) |=> (colStrobe && !rowStrobe)); // R4
  AST_MISS_OPENS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (req && !busy && !pageHit) |=> rowStrobe); // R3
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rowStrobe && colStrobe)); // R3
  AST_COL_HELD_IN_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rowStrobe && !colStrobe) |-> $stable(memCol)); // R9
  AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (colStrobe && $past(rvalid)) |->
      (memCol[COL_W-1:2] == $past(memCol[COL_W-1:2]) &&
       memCol[1:0] == $past(memCol[1:0]) + 2'd1)); // R12
endmodule

bind page_burst_seq page_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .req(req), .busy(busy), .rvalid(rvalid),
  .rowStrobe(rowStrobe), .colStrobe(colStrobe), .pageHit(pageHit), .memCol(memCol)
);

// File: tb/page_burst_seq_test.sv
`timescale 1ns/1ps
module page_burst_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0;
  logic [15:0] addr = '0;
  logic burst = 1'b0;
  logic [3:0] cfgRowCycles = 4'd2, cfgColCycles = 4'd3, cfgBeatCycles = 4'd3;
  logic cfgBurstMode = 1'b1;
  logic busy, rvalid, rowStrobe, colStrobe;
  logic [31:0] rdata, memRdata;
  logic [7:0] memRow, memCol, rowLat, colLat, rowEff, colEff;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  page_burst_seq uut (
    .clk(clk), .rstN(rstN), .req(req), .addr(addr), .burst(burst),
    .cfgRowCycles(cfgRowCycles), .cfgColCycles(cfgColCycles),
    .cfgBeatCycles(cfgBeatCycles), .cfgBurstMode(cfgBurstMode),
    .busy(busy), .rvalid(rvalid), .rdata(rdata), .rowStrobe(rowStrobe),
    .colStrobe(colStrobe), .memRow(memRow), .memCol(memCol), .memRdata(memRdata)
  );

  // behavioural array: transparent while strobed, held afterwards
  always_ff @(posedge clk) begin
    if (rowStrobe) rowLat <= memRow;
    if (colStrobe) colLat <= memCol;
  end
  assign rowEff = rowStrobe ? memRow : rowLat;
  assign colEff = colStrobe ? memCol : colLat;
  assign memRdata = {rowEff, colEff, rowEff ^ 8'h5A, colEff ^ 8'hA5};

  function automatic logic [31:0] expWord(input logic [15:0] a);
    return {a[15:8], a[7:0], a[15:8] ^ 8'h5A, a[7:0] ^ 8'hA5};
  endfunction

  task automatic check(input bit ok, input string req_tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic setCfg(input int r, input int c, input int b, input bit m);
    cfgRowCycles = 4'(r); cfgColCycles = 4'(c); cfgBeatCycles = 4'(b); cfgBurstMode = m;
  endtask

  // issue one request and check its whole beat pattern
  task automatic doAccess(input logic [15:0] a, input bit isBurst, input int x,
                          input int y, input int expRows, input bit junk, input string tag);
    int beats = isBurst ? 4 : 1;
    int last = x + (beats - 1) * y;
    int rows = 0, cols = 0, badTime = 0, badData = 0, badBusy = 0, gotBeats = 0;
    logic [31:0] lastBad = '0, lastExp = '0;
    @(negedge clk);
    req = 1'b1; addr = a; burst = isBurst;
    for (int j = 1; j <= last + 1; j++) begin
      @(negedge clk);
      if (j == 1) req = 1'b0;
      if (junk && j == 2) begin req = 1'b1; addr = 16'h9900; burst = 1'b1; end
      if (junk && j == 4) req = 1'b0;
      if (j <= last) begin
        bit expV = (j >= x) && ((j - x) % y == 0);
        if (!busy) badBusy++;
        if (rvalid != expV) badTime++;
        if (rvalid && expV) begin
          logic [15:0] wa = {a[15:2], 2'(a[1:0] + 2'((j - x) / y))};
          gotBeats++;
          if (rdata !== expWord(wa)) begin badData++; lastBad = rdata; lastExp = expWord(wa); end
        end
        if (rowStrobe) rows++;
        if (colStrobe) cols++;
      end else begin
        check(!busy && !rvalid, "R2", {tag, " idle after last beat"}, {busy, rvalid}, 0);
      end
    end
    check(badBusy == 0, "R2", {tag, " busy during access"}, badBusy, 0);
    check(badTime == 0 && gotBeats == beats, tag, "beat timing mismatches", badTime, 0);
    check(badData == 0, "R9", {tag, " burst word data"}, lastBad, lastExp);
    check(rows == expRows, tag, "row strobe count", rows, expRows);
    check(cols == beats, "R5", {tag, " column strobe count"}, cols, beats);
  endtask

  task automatic testReset();
    check(!busy && !rvalid && !rowStrobe && !colStrobe, "R1", "outputs after reset",
          {busy, rvalid, rowStrobe, colStrobe}, 0);
  endtask

  task automatic testFpmMiss();   // R1 R3 R5 R6 R12: first access misses, 5-3-3-3
    setCfg(2, 3, 3, 1);
    doAccess(16'h1235, 1, 5, 3, 1, 0, "R3_R6_fpm_miss");
  endtask

  task automatic testFpmHit();    // R4 R10: same page, no row setup
    doAccess(16'h1202, 1, 3, 3, 0, 0, "R4_R10_fpm_hit");
  endtask

  task automatic testEdo();       // R6: 5-2-2-2
    setCfg(2, 3, 2, 1);
    doAccess(16'h4410, 1, 5, 2, 1, 0, "R6_edo_miss");
  endtask

  task automatic testNoBurst();   // R7: 5-5-5-5, row per beat
    setCfg(2, 3, 3, 0);
    doAccess(16'h7701, 1, 5, 5, 4, 0, "R7_noburst");
  endtask

  task automatic testSingle();    // R8: one word
    doAccess(16'h7705, 0, 3, 3, 0, 0, "R8_single");
  endtask

  task automatic testBusyIgnore(); // R11: request during burst is dropped
    setCfg(2, 3, 3, 1);
    doAccess(16'h7708, 1, 3, 3, 0, 1, "R11_busy_req");
    doAccess(16'h7702, 0, 3, 3, 0, 0, "R11_page_kept");
  endtask

  task automatic testFastest();   // R5 R12: 2-1-1-1, start at group offset 3
    setCfg(1, 1, 1, 1);
    doAccess(16'hABCF, 1, 2, 1, 1, 0, "R5_R12_fast_wrap");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFpmMiss();
    testFpmHit();
    testEdo();
    testNoBurst();
    testSingle();
    testBusyIgnore();
    testFastest();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule